// File: doc/BRIEF.md
# Energy-Detection Receiver Acquisition Sequencer

This block steps an impulse-radio energy-detection receiver from an idle channel to live data reception. It first learns the noise floor. It sums the integrate-and-dump ADC codes over one bit period and adds a programmable margin to form a detection threshold. It then measures the next bit period. If the energy there is not above the threshold, it goes back and relearns the noise.

Once a signal has been seen, the block runs a closed-loop search over a gain index. The index selects one entry of an external gain table that drives the variable-gain amplifier. The search moves away from ADC saturation and away from codes too small to resolve. After the gain settles, the block starts coarse synchronization. When that completes, it starts demodulation and fine synchronization together and waits for the end of reception.

Timeouts on the synchronizer and demodulator handshakes return the block to noise learning, and so does a gain search that runs out of range. While data is arriving, a ranging command raises a request to prepare a reply packet.

Top module: `edrx_acq_ctrl`

## Requirements
- R1: After `acq_en` is seen in idle, the block enters noise learning (`phase` 1). It sums the next BIT_SAMPLES strobed ADC codes and sets the threshold to min(sum + `cfg_margin`, 2^ACC_W − 1), where ACC_W = ADC_W + clog2(BIT_SAMPLES). It then enters detection (`phase` 2).
- R2: In detection the block sums the next BIT_SAMPLES strobed codes. A sum strictly greater than the threshold enters the gain phase (`phase` 3). A sum equal to or below the threshold returns to noise learning with a fresh window.
- R3: On entry to the gain phase, the gain index is loaded with mid-scale, 2^(IDX_W−1) (8 for a 4-bit index).
- R4: On each strobe in the gain phase, a full-scale code (2^ADC_W − 1) lowers the index by one and a code below `cfg_floor` raises it by one.
- R5: On a strobe in the gain phase whose code is below full scale and at or above `cfg_floor`, the gain settles. The block enters coarse synchronization (`phase` 4) with a one-cycle `csync_start`, and the index is held.
- R6: A full-scale code at index 0, or a below-floor code at the top index, is a gain failure. The block gives a one-cycle `acq_fail`, returns to noise learning and leaves the index where it was.
- R7: `csync_done` in coarse synchronization enters data reception (`phase` 5) with a one-cycle `data_start`, which launches demodulation and fine synchronization together.
- R8: If no done handshake arrives within TMO_CYC cycles in coarse synchronization or in data reception, the block gives a one-cycle `sync_tmo` and returns to noise learning.
- R9: `rng_cmd` in data reception gives a one-cycle `reply_req` in the next cycle. In any other phase `rng_cmd` has no effect on any output.
- R10: `demod_done` in data reception returns the block to idle (`phase` 0). Strobes in idle change no output.
- R11: Under reset the block is idle (`phase` 0), the gain index is mid-scale and every pulse output is low. All outputs are registered, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Start acquisition from idle |
| integ_strobe | input | 1 | One integrate-and-dump result is valid on `adc_code` |
| adc_code | input | ADC_W | Quantized integrated energy |
| cfg_margin | input | ADC_W+clog2(BIT_SAMPLES) | Margin added to the learned noise energy |
| cfg_floor | input | ADC_W | Lowest ADC code that the gain search accepts |
| csync_done | input | 1 | Coarse synchronizer reports lock |
| demod_done | input | 1 | Demodulator reports end of reception |
| rng_cmd | input | 1 | Ranging command decoded from the payload |
| gain_idx | output | IDX_W | Index into the amplifier gain table |
| phase | output | 3 | 0 idle, 1 noise, 2 detect, 3 gain, 4 coarse sync, 5 data |
| csync_start | output | 1 | One-cycle start to the coarse synchronizer |
| data_start | output | 1 | One-cycle start to the demodulator and fine synchronizer |
| reply_req | output | 1 | One-cycle request to prepare a ranging reply |
| acq_fail | output | 1 | One-cycle gain-search failure |
| sync_tmo | output | 1 | One-cycle handshake timeout |

## Verification
The bench builds the block with a 4-bit ADC, a 4-bit gain index, four strobes per bit period and a 20-cycle handshake timeout. The short bit window lets a four-code window reach a 6-bit threshold. With a margin of 63 the threshold saturates, and an ordinary strong window then fails to cross it. The short timeout lets both handshake timeouts run out in a few dozen cycles. The 16-entry index range is small enough to walk the index from mid-scale to each limit and into a failure in both directions.

// File: rtl/edrx_pkg.sv
package edrx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_NOISE  = 3'd1,
    PH_DETECT = 3'd2,
    PH_GAIN   = 3'd3,
    PH_CSYNC  = 3'd4,
    PH_DATA   = 3'd5
  } phase_e;

endpackage

// File: rtl/edrx_energy_acc.sv
// Sums BIT_SAMPLES strobed codes into one bit-period energy value.
module edrx_energy_acc #(
  parameter int ADC_W       = 4,
  parameter int BIT_SAMPLES = 8,
  parameter int ACC_W       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             strobe,
  input  logic [ADC_W-1:0] code,
  output logic             bit_done,
  output logic [ACC_W-1:0] bit_energy
);

  localparam int CNT_W = (BIT_SAMPLES > 1) ? $clog2(BIT_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      bit_done   <= 1'b0;
      bit_energy <= '0;
    end else if (clr) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      bit_done <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (strobe) begin
        if (cnt_q == LAST) begin
          bit_energy <= acc_q + ACC_W'(code);
          acc_q      <= '0;
          cnt_q      <= '0;
          bit_done   <= 1'b1;
        end else begin
          acc_q <= acc_q + ACC_W'(code);
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // a finished window always leaves the sample counter rewound
  AST_WINDOW_REWOUND: assert property (@(posedge clk) disable iff (rst)
    bit_done |-> (cnt_q == '0)); // R1

  // a cleared accumulator reports no window in the following cycle
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (clr && !$past(rst)) |=> !bit_done); // R2

endmodule

// File: rtl/edrx_gain_search.sv
// Closed-loop walk of the amplifier gain index.
module edrx_gain_search #(
  parameter int ADC_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_mid,
  input  logic             step_en,
  input  logic [ADC_W-1:0] code,
  input  logic [ADC_W-1:0] floor_code,
  output logic [IDX_W-1:0] gain_idx,
  output logic             settle,
  output logic             fail
);

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'((2 ** IDX_W) - 1);
  localparam logic [IDX_W-1:0] IDX_MID = IDX_W'(2 ** (IDX_W - 1));
  localparam logic [ADC_W-1:0] FULL    = ADC_W'((2 ** ADC_W) - 1);

  logic too_hot, too_cold;
  assign too_hot  = (code == FULL);
  assign too_cold = (code < floor_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_idx <= IDX_MID;
      settle   <= 1'b0;
      fail     <= 1'b0;
    end else begin
      settle <= 1'b0;
      fail   <= 1'b0;
      if (load_mid) begin
        gain_idx <= IDX_MID;
      end else if (step_en) begin
        if (too_hot) begin
          if (gain_idx == '0) fail <= 1'b1;
          else                gain_idx <= gain_idx - IDX_W'(1);
        end else if (too_cold) begin
          if (gain_idx == IDX_MAX) fail <= 1'b1;
          else                     gain_idx <= gain_idx + IDX_W'(1);
        end else begin
          settle <= 1'b1;
        end
      end
    end
  end

  AST_GAIN_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_mid) && !$past(rst)) |->
      ((gain_idx == $past(gain_idx)) ||
       (gain_idx == $past(gain_idx) + IDX_W'(1)) ||
       (gain_idx == $past(gain_idx) - IDX_W'(1)))); // R4

  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fail |-> ((gain_idx == '0) || (gain_idx == IDX_MAX))); // R6

  AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (settle && !$past(rst)) |-> (gain_idx == $past(gain_idx))); // R5

  AST_MID_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_mid && !$past(rst)) |=> (gain_idx == IDX_MID)); // R3

endmodule

// File: rtl/edrx_seq_fsm.sv
// Acquisition sequencer: noise learning, detection, gain, sync, data.
module edrx_seq_fsm #(
  parameter int ACC_W   = 7,
  parameter int TMO_CYC = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acq_en,
  input  logic                integ_strobe,
  input  logic                bit_done,
  input  logic [ACC_W-1:0]    bit_energy,
  input  logic [ACC_W-1:0]    cfg_margin,
  input  logic                settle,
  input  logic                fail,
  input  logic                csync_done,
  input  logic                demod_done,
  input  logic                rng_cmd,
  output edrx_pkg::phase_e    phase,
  output logic                acc_clr,
  output logic                load_mid,
  output logic                step_en,
  output logic                csync_start,
  output logic                data_start,
  output logic                reply_req,
  output logic                acq_fail,
  output logic                sync_tmo
);
  import edrx_pkg::*;

  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  phase_e           nxt;
  logic [ACC_W-1:0] thr_q;
  logic [TMO_W-1:0] tmo_q;
  logic             tmo_hit;
  logic [ACC_W:0]   thr_sum;
  logic [ACC_W-1:0] thr_sat;

  assign tmo_hit  = (tmo_q == TMO_LAST);
  assign thr_sum  = {1'b0, bit_energy} + {1'b0, cfg_margin};
  assign thr_sat  = thr_sum[ACC_W] ? '1 : thr_sum[ACC_W-1:0];
  assign acc_clr  = (phase != PH_NOISE) && (phase != PH_DETECT);
  assign step_en  = integ_strobe && (phase == PH_GAIN) && !settle && !fail;

  always_comb begin
    nxt      = phase;
    load_mid = 1'b0;
    case (phase)
      PH_IDLE:   if (acq_en) nxt = PH_NOISE;
      PH_NOISE:  if (bit_done) nxt = PH_DETECT;
      PH_DETECT: if (bit_done) begin
                   if (bit_energy > thr_q) begin
                     nxt      = PH_GAIN;
                     load_mid = 1'b1;
                   end else begin
                     nxt = PH_NOISE;
                   end
                 end
      PH_GAIN:   if (settle) nxt = PH_CSYNC;
                 else if (fail) nxt = PH_NOISE;
      PH_CSYNC:  if (csync_done) nxt = PH_DATA;
                 else if (tmo_hit) nxt = PH_NOISE;
      PH_DATA:   if (demod_done) nxt = PH_IDLE;
                 else if (tmo_hit) nxt = PH_NOISE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      thr_q       <= '0;
      tmo_q       <= '0;
      csync_start <= 1'b0;
      data_start  <= 1'b0;
      reply_req   <= 1'b0;
      acq_fail    <= 1'b0;
      sync_tmo    <= 1'b0;
    end else begin
      phase       <= nxt;
      csync_start <= (phase == PH_GAIN) && settle;
      data_start  <= (phase == PH_CSYNC) && csync_done;
      acq_fail    <= (phase == PH_GAIN) && !settle && fail;
      sync_tmo    <= tmo_hit &&
                     (((phase == PH_CSYNC) && !csync_done) ||
                      ((phase == PH_DATA) && !demod_done));
      reply_req   <= (phase == PH_DATA) && rng_cmd;
      if ((phase == PH_NOISE) && bit_done) thr_q <= thr_sat;
      if (nxt != phase)
        tmo_q <= '0;
      else if ((phase == PH_CSYNC) || (phase == PH_DATA))
        tmo_q <= tmo_q + TMO_W'(1);
    end
  end

  AST_DETECT_GATE: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_GAIN) && ($past(phase) == PH_DETECT) && !$past(rst)) |->
      ($past(bit_energy) > $past(thr_q))); // R2

  AST_THR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (($past(phase) == PH_NOISE) && $past(bit_done) && !$past(rst)) |->
      ((thr_q >= $past(bit_energy)) && (thr_q >= $past(cfg_margin)))); // R1

  AST_CSYNC_START_PHASE: assert property (@(posedge clk) disable iff (rst)
    csync_start |-> (phase == PH_CSYNC)); // R5

  AST_DATA_START_PHASE: assert property (@(posedge clk) disable iff (rst)
    data_start |-> (phase == PH_DATA)); // R7

  AST_TMO_TO_NOISE: assert property (@(posedge clk) disable iff (rst)
    sync_tmo |-> (phase == PH_NOISE)); // R8

  AST_FAIL_TO_NOISE: assert property (@(posedge clk) disable iff (rst)
    acq_fail |-> (phase == PH_NOISE)); // R6

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({csync_start, data_start, acq_fail, sync_tmo})); // R11

  AST_REPLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    (reply_req && !$past(rst)) |-> ($past(phase) == PH_DATA)); // R9

endmodule

// File: rtl/edrx_acq_ctrl.sv
// Top: acquisition controller for an energy-detection receiver.
module edrx_acq_ctrl #(
  parameter int ADC_W       = 4,
  parameter int BIT_SAMPLES = 8,
  parameter int IDX_W       = 4,
  parameter int TMO_CYC     = 4096
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  acq_en,
  input  logic                                  integ_strobe,
  input  logic [ADC_W-1:0]                      adc_code,
  input  logic [ADC_W+$clog2(BIT_SAMPLES)-1:0]  cfg_margin,
  input  logic [ADC_W-1:0]                      cfg_floor,
  input  logic                                  csync_done,
  input  logic                                  demod_done,
  input  logic                                  rng_cmd,
  output logic [IDX_W-1:0]                      gain_idx,
  output logic [2:0]                            phase,
  output logic                                  csync_start,
  output logic                                  data_start,
  output logic                                  reply_req,
  output logic                                  acq_fail,
  output logic                                  sync_tmo
);
  import edrx_pkg::*;

  localparam int ACC_W = ADC_W + $clog2(BIT_SAMPLES);

  logic             bit_done;
  logic [ACC_W-1:0] bit_energy;
  logic             acc_clr, load_mid, step_en, settle, fail;
  phase_e           phase_s;

  edrx_energy_acc #(
    .ADC_W(ADC_W), .BIT_SAMPLES(BIT_SAMPLES), .ACC_W(ACC_W)
  ) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .strobe(integ_strobe),
    .code(adc_code), .bit_done(bit_done), .bit_energy(bit_energy)
  );

  edrx_gain_search #(
    .ADC_W(ADC_W), .IDX_W(IDX_W)
  ) u_gain (
    .clk(clk), .rst(rst), .load_mid(load_mid), .step_en(step_en),
    .code(adc_code), .floor_code(cfg_floor), .gain_idx(gain_idx),
    .settle(settle), .fail(fail)
  );

  edrx_seq_fsm #(
    .ACC_W(ACC_W), .TMO_CYC(TMO_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .acq_en(acq_en), .integ_strobe(integ_strobe),
    .bit_done(bit_done), .bit_energy(bit_energy), .cfg_margin(cfg_margin),
    .settle(settle), .fail(fail), .csync_done(csync_done),
    .demod_done(demod_done), .rng_cmd(rng_cmd), .phase(phase_s),
    .acc_clr(acc_clr), .load_mid(load_mid), .step_en(step_en),
    .csync_start(csync_start), .data_start(data_start),
    .reply_req(reply_req), .acq_fail(acq_fail), .sync_tmo(sync_tmo)
  );

  assign phase = phase_s;

endmodule

// File: tb/edrx_acq_ctrl_bench.sv
module edrx_acq_ctrl_bench;

  localparam int ADC_W = 4, BIT_SAMPLES = 4, IDX_W = 4, TMO_CYC = 20;
  localparam int ACC_W = 6;

  localparam logic [2:0] P_IDLE = 3'd0, P_NOISE = 3'd1, P_DET = 3'd2,
                         P_GAIN = 3'd3, P_CSYNC = 3'd4, P_DATA = 3'd5;
  // pulse field order: csync_start, data_start, reply_req, acq_fail, sync_tmo
  localparam logic [4:0] NP = 5'b00000, CS = 5'b10000, DS = 5'b01000,
                         RR = 5'b00100, AF = 5'b00010, TO = 5'b00001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acq_en = 1'b0, integ_strobe = 1'b0;
  logic [ADC_W-1:0] adc_code = '0;
  logic [ACC_W-1:0] cfg_margin = '0;
  logic [ADC_W-1:0] cfg_floor = '0;
  logic csync_done = 1'b0, demod_done = 1'b0, rng_cmd = 1'b0;
  logic [IDX_W-1:0] gain_idx;
  logic [2:0] phase;
  logic csync_start, data_start, reply_req, acq_fail, sync_tmo;

  edrx_acq_ctrl #(
    .ADC_W(ADC_W), .BIT_SAMPLES(BIT_SAMPLES), .IDX_W(IDX_W), .TMO_CYC(TMO_CYC)
  ) u_edrx_acq_ctrl (
    .clk(clk), .rst(rst), .acq_en(acq_en), .integ_strobe(integ_strobe),
    .adc_code(adc_code), .cfg_margin(cfg_margin), .cfg_floor(cfg_floor),
    .csync_done(csync_done), .demod_done(demod_done), .rng_cmd(rng_cmd),
    .gain_idx(gain_idx), .phase(phase), .csync_start(csync_start),
    .data_start(data_start), .reply_req(reply_req), .acq_fail(acq_fail),
    .sync_tmo(sync_tmo)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [11:0] exp_q[$];
  string tag_q[$];
  logic [6:0] prev_pg;
  logic [11:0] cur_ev, exp_ev;
  string cur_tag;

  task automatic push(input logic [2:0] ph, input logic [3:0] g,
                      input logic [4:0] pl, input string tag);
    exp_q.push_back({ph, g, pl});
    tag_q.push_back(tag);
  endtask

  // monitor: any phase/gain change or any pulse is an event to be matched
  always @(negedge clk) begin
    if (mon_on) begin
      cur_ev = {phase, gain_idx, csync_start, data_start, reply_req, acq_fail, sync_tmo};
      if ((cur_ev[11:5] != prev_pg) || (|cur_ev[4:0])) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R9 unexpected event actual=%h expected=none", cur_ev);
        end else begin
          exp_ev  = exp_q.pop_front();
          cur_tag = tag_q.pop_front();
          if (cur_ev !== exp_ev) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", cur_tag, cur_ev, exp_ev);
          end
        end
      end
      prev_pg = cur_ev[11:5];
    end
  end

  task automatic strobe(input logic [3:0] c);
    @(negedge clk); adc_code = c; integ_strobe = 1'b1;
    @(negedge clk); integ_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] c, input logic [3:0] d);
    strobe(a); strobe(b); strobe(c); strobe(d);
  endtask

  task automatic do_acq();
    @(negedge clk); acq_en = 1'b1;
    @(negedge clk); acq_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_csync_done();
    @(negedge clk); csync_done = 1'b1;
    @(negedge clk); csync_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_demod_done();
    @(negedge clk); demod_done = 1'b1;
    @(negedge clk); demod_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_rng();
    @(negedge clk); rng_cmd = 1'b1;
    @(negedge clk); rng_cmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cfg_margin = 6'd6;
    cfg_floor  = 4'd5;
    repeat (4) @(negedge clk);
    // R11: reset state
    checks++;
    if ({phase, gain_idx, csync_start, data_start, reply_req, acq_fail, sync_tmo}
        !== {P_IDLE, 4'd8, NP}) begin
      failures++;
      $display("FAIL R11 reset actual=%h expected=%h",
               {phase, gain_idx, csync_start, data_start, reply_req, acq_fail, sync_tmo},
               {P_IDLE, 4'd8, NP});
    end
    rst = 1'b0;
    prev_pg = {phase, gain_idx};
    mon_on = 1'b1;

    // full path with threshold equality bounce
    push(P_NOISE, 4'd8, NP, "R1"); do_acq();
    push(P_DET,   4'd8, NP, "R1"); send_bit(1, 2, 1, 2);      // thr 12
    push(P_NOISE, 4'd8, NP, "R2"); send_bit(3, 3, 3, 3);      // 12, not above
    push(P_DET,   4'd8, NP, "R1"); send_bit(2, 2, 2, 2);      // thr 14
    push(P_GAIN,  4'd8, NP, "R3"); send_bit(4, 4, 4, 3);      // 15 > 14
    push(P_GAIN,  4'd7, NP, "R4"); strobe(15);
    push(P_GAIN,  4'd6, NP, "R4"); strobe(15);
    push(P_GAIN,  4'd7, NP, "R4"); strobe(2);
    push(P_CSYNC, 4'd7, CS, "R5"); strobe(5);                 // floor itself accepted
    do_rng();                                                 // R9: ignored in coarse sync
    push(P_DATA,  4'd7, DS, "R7"); do_csync_done();
    push(P_DATA,  4'd7, RR, "R9"); do_rng();
    push(P_IDLE,  4'd7, NP, "R10"); do_demod_done();
    strobe(15);                                               // R10: idle ignores strobes
    repeat (4) @(negedge clk);

    // coarse sync timeout
    push(P_NOISE, 4'd7, NP, "R1"); do_acq();
    push(P_DET,   4'd7, NP, "R1"); send_bit(0, 0, 0, 0);      // thr 6
    push(P_GAIN,  4'd8, NP, "R3"); send_bit(5, 5, 5, 5);
    push(P_CSYNC, 4'd8, CS, "R5"); strobe(14);
    push(P_NOISE, 4'd8, TO, "R8"); repeat (25) @(negedge clk);

    // data timeout
    push(P_DET,   4'd8, NP, "R1"); send_bit(0, 0, 0, 0);
    push(P_GAIN,  4'd8, NP, "R3"); send_bit(5, 5, 5, 5);
    push(P_CSYNC, 4'd8, CS, "R5"); strobe(7);
    push(P_DATA,  4'd8, DS, "R7"); do_csync_done();
    push(P_NOISE, 4'd8, TO, "R8"); repeat (25) @(negedge clk);

    // gain runs off the top
    push(P_DET,   4'd8, NP, "R1"); send_bit(0, 0, 0, 0);
    push(P_GAIN,  4'd8, NP, "R3"); send_bit(5, 5, 5, 5);
    for (int i = 9; i <= 15; i++) begin
      push(P_GAIN, 4'(i), NP, "R4"); strobe(0);
    end
    push(P_NOISE, 4'd15, AF, "R6"); strobe(0);

    // gain runs off the bottom
    push(P_DET,   4'd15, NP, "R1"); send_bit(0, 0, 0, 0);
    push(P_GAIN,  4'd8,  NP, "R3"); send_bit(5, 5, 5, 5);
    for (int i = 7; i >= 0; i--) begin
      push(P_GAIN, 4'(i), NP, "R4"); strobe(15);
    end
    push(P_NOISE, 4'd0, AF, "R6"); strobe(15);

    // threshold saturation
    cfg_margin = 6'd63;
    push(P_DET,   4'd0, NP, "R1"); send_bit(0, 0, 0, 0);      // thr 63
    push(P_NOISE, 4'd0, NP, "R1"); send_bit(15, 15, 15, 15);  // 60
    push(P_DET,   4'd0, NP, "R1"); send_bit(15, 15, 15, 15);  // 60+63 saturates
    push(P_NOISE, 4'd0, NP, "R1"); send_bit(15, 15, 15, 15);  // 60 not above 63

    // zero margin, smallest crossing
    cfg_margin = 6'd0;
    push(P_DET,   4'd0, NP, "R1"); send_bit(0, 0, 0, 0);      // thr 0
    push(P_GAIN,  4'd8, NP, "R2"); send_bit(1, 0, 0, 0);
    repeat (6) @(negedge clk);

    mon_on = 1'b0;
    while (exp_q.size() != 0) begin
      checks++;
      failures++;
      cur_tag = tag_q.pop_front();
      $display("FAIL %s missing event actual=none expected=%h", cur_tag, exp_q.pop_front());
    end
    finish_run();
  end

endmodule